// File: doc/BRIEF.md
# Software Interrupt Claim Controller

This block lets any hart post a software interrupt to any other hart and lets the target hart service it through a claim and complete exchange. Every hart owns one source, and source 0 is reserved and never valid. A pending bitmap records raised sources. Each source has a priority word. Each hart has an enable word, an in-service record and a claim/complete register. The block drives one interrupt request line per hart.

Software reaches the block through a plain 32-bit register port. A request is presented for one cycle with valid, write, address and data. A read answers one cycle later with a response valid pulse. A claim read takes the best qualifying source for the hart that owns the addressed claim register. It clears that source's pending bit and holds the source in service until the same ID is written back to that hart's claim register.

Top module: `swi_claim_ctrl`

## Requirements
- R1: Bit 0 of the pending bitmap and of every enable word always reads as zero, and a one written to bit 0 is dropped.
- R2: The interrupt aimed at hart h is source h+1. Its pending and enable bit is bit h+1. Its priority word is at byte offset 4*(h+1). Priority reads of source 0 or of a source above the hart count return zero.
- R3: The pending word is at offset 0x1000 and reads back the bitmap. A write sets each bit that is one in the data and leaves the others unchanged, so writing zeros clears nothing.
- R4: Hart h's enable word is at offset 0x2000 + 0x80*h. Only bits 1 to NUM_HARTS are stored, and every other bit reads as zero.
- R5: A priority word keeps the low PRIO_W bits of the written data and reads back zero-extended.
- R6: A read of hart h's claim register at 0x200004 + 0x1000*h returns the qualifying source with the greatest priority. When two sources tie, the one with the lower ID wins. A qualifying source is pending, enabled for h, not in service and has a nonzero priority.
- R7: A claim read clears the pending bit of the source it returns. When no source qualifies it returns 0 and changes nothing.
- R8: A claimed source stays in service for the claiming hart and cannot be claimed by any hart until that hart writes its ID to its own claim register. Completion writes carrying any other ID, or arriving at another hart's claim register, are ignored.
- R9: irq[h] is high exactly when some source qualifies for hart h in the sense of R6. It follows a register write on the next cycle.
- R10: A source whose priority is 0 never raises an interrupt and is never returned by a claim, even while pending.
- R11: Misaligned and unmapped offsets read as zero, and writes to them change nothing. Unmapped offsets include enable and claim words of harts at or above NUM_HARTS.
- R12: After reset all pending, enable, in-service and priority state is zero, all irq lines are low and no response is signalled.
- R13: Every read request produces rsp_valid with its data exactly one cycle later. No other cycle carries rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | NUM_HARTS | Interrupt request, one line per hart |

## Verification
Read data, including the result of a claim, arrives on the clock edge after the request. The monitor compares each response at the falling edge where rsp_valid is first seen, popping the value the driver queued when it issued the read. Pending, enable, priority and in-service updates take effect on the edge that accepts the write, and irq is combinational from that state. The bench therefore samples irq at the falling edge that ends the write cycle, and the following claim read sees the updated state. Corner checks cover a re-raised source while it is in service, completions from the wrong hart or with the wrong ID, priority ties, priority 0 and unmapped claim windows.

// File: rtl/swi_pkg.sv
package swi_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 5;

  localparam int unsigned OFF_PEND       = 32'h0000_1000;
  localparam int unsigned OFF_EN_BASE    = 32'h0000_2000;
  localparam int unsigned OFF_CLAIM_BASE = 32'h0020_0004;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [ID_W-1:0]  idx;
  } reg_sel_t;

endpackage

// File: rtl/swi_reg_decode.sv
module swi_reg_decode
  import swi_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 22
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int unsigned NSRC = NUM_HARTS + 1;
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-14:0] EN_HI = {{(ADDR_W-14){1'b0}}, 1'b1};

  logic [9:0] word;
  logic [5:0] en_hart;
  logic [8:0] cl_hart;

  assign word    = addr[11:2];
  assign en_hart = addr[12:7];
  assign cl_hart = addr[20:12];

  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == PEND_A) begin
        sel.kind = RK_PEND;
      end else if (addr[ADDR_W-1:12] == '0) begin
        if ((word != '0) && (word < 10'(NSRC))) begin
          sel.kind = RK_PRIO;
          sel.idx  = word[ID_W-1:0];
        end
      end else if ((addr[ADDR_W-1:13] == EN_HI) && (addr[6:0] == '0)) begin
        if (en_hart < 6'(NUM_HARTS)) begin
          sel.kind = RK_EN;
          sel.idx  = en_hart[ID_W-1:0];
        end
      end else if ((addr[ADDR_W-1:21] != '0) && (addr[11:0] == 12'h004)) begin
        if ((addr[ADDR_W-1:21] == {{(ADDR_W-22){1'b0}}, 1'b1}) &&
            (cl_hart < 9'(NUM_HARTS))) begin
          sel.kind = RK_CLAIM;
          sel.idx  = cl_hart[ID_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/swi_prio_bank.sv
module swi_prio_bank
  import swi_pkg::*;
#(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   we,
  input  logic [ID_W-1:0]        idx,
  input  logic [PRIO_W-1:0]      wdata,
  output logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [PRIO_W-1:0]      rd_prio
);

  assign prio_flat[PRIO_W-1:0] = '0;

  for (genvar s = 1; s < NSRC; s++) begin : g_src
    logic [PRIO_W-1:0] prio_q;
    logic              ld;

    assign ld = we && (idx == ID_W'(s));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q <= '0;
      end else if (ld) begin
        prio_q <= wdata;
      end
    end

    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q;
  end

  always_comb begin
    rd_prio = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (idx == ID_W'(s)) rd_prio = prio_flat[s*PRIO_W +: PRIO_W];
    end
  end

endmodule

// File: rtl/swi_hart_arb.sv
module swi_hart_arb
  import swi_pkg::*;
#(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned PRIO_W = 3
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [ID_W-1:0]        best_id,
  output logic                   hit
);

  logic [PRIO_W-1:0] best_p;

  // Strictly-greater scan upward: ties keep the lower ID, priority 0 never wins.
  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int s = 1; s < NSRC; s++) begin
      if (cand[s] && (prio_flat[s*PRIO_W +: PRIO_W] > best_p)) begin
        best_p  = prio_flat[s*PRIO_W +: PRIO_W];
        best_id = ID_W'(s);
      end
    end
  end

  assign hit = (best_id != '0);

endmodule

// File: rtl/swi_claim_ctrl.sv
module swi_claim_ctrl
  import swi_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned ADDR_W    = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_HARTS-1:0] irq
);

  localparam int unsigned NSRC   = NUM_HARTS + 1;
  localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam logic [NSRC-1:0] ONE_HOT0 = {{(NSRC-1){1'b0}}, 1'b1};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // decode
  reg_sel_t sel;
  logic     wr, rd;
  logic [HART_W-1:0] hsel;

  swi_reg_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  assign wr   = req_valid &&  req_write;
  assign rd   = req_valid && !req_write;
  assign hsel = sel.idx[HART_W-1:0];

  // priorities
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [PRIO_W-1:0]      rd_prio;

  swi_prio_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_prio (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .we        (wr && (sel.kind == RK_PRIO)),
    .idx       (sel.idx),
    .wdata     (req_wdata[PRIO_W-1:0]),
    .prio_flat (prio_flat),
    .rd_prio   (rd_prio)
  );

  // state
  logic [NSRC-1:0] pend_q, pend_d;
  logic            pend_we;
  logic [NSRC-1:0] en_q    [NUM_HARTS];
  logic [NSRC-1:0] insvc_q [NUM_HARTS];
  logic [NSRC-1:0] insvc_d [NUM_HARTS];
  logic [NUM_HARTS-1:0] en_we, insvc_we;
  logic [NSRC-1:0] busy;

  always_comb begin
    busy = '0;
    for (int h = 0; h < NUM_HARTS; h++) busy = busy | insvc_q[h];
  end

  // per-hart arbitration
  logic [ID_W-1:0] best_id [NUM_HARTS];

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic [NSRC-1:0] cand;
    assign cand = pend_q & en_q[h] & ~busy;

    swi_hart_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .cand      (cand),
      .prio_flat (prio_flat),
      .best_id   (best_id[h]),
      .hit       (irq[h])
    );
  end

  // claim / complete
  logic            claim_rd, cmp_wr;
  logic [ID_W-1:0] claim_id;
  logic [NSRC-1:0] claim_mask, cmp_mask, set_mask;

  assign claim_rd = rd && (sel.kind == RK_CLAIM);
  assign cmp_wr   = wr && (sel.kind == RK_CLAIM);
  assign claim_id = claim_rd ? best_id[hsel] : '0;

  always_comb begin
    claim_mask = '0;
    if (claim_id != '0) claim_mask = ONE_HOT0 << claim_id;
    cmp_mask = '0;
    if (cmp_wr && (req_wdata < 32'(NSRC))) cmp_mask = ONE_HOT0 << req_wdata[ID_W-1:0];
    set_mask = '0;
    if (wr && (sel.kind == RK_PEND)) set_mask = {req_wdata[NSRC-1:1], 1'b0};
  end

  // next state
  always_comb begin
    pend_we = (set_mask != '0) || (claim_mask != '0);
    pend_d  = (pend_q | set_mask) & ~claim_mask;
    for (int h = 0; h < NUM_HARTS; h++) begin
      en_we[h]    = wr && (sel.kind == RK_EN) && (hsel == HART_W'(h));
      insvc_we[h] = (claim_rd && (claim_mask != '0) && (hsel == HART_W'(h))) ||
                    (cmp_wr && (hsel == HART_W'(h)));
      insvc_d[h]  = (insvc_q[h] | (claim_rd ? claim_mask : '0)) & ~cmp_mask;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (pend_we) begin
      pend_q <= pend_d;
    end
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hstate
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[h] <= '0;
      end else if (en_we[h]) begin
        en_q[h] <= {req_wdata[NSRC-1:1], 1'b0};
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        insvc_q[h] <= '0;
      end else if (insvc_we[h]) begin
        insvc_q[h] <= insvc_d[h];
      end
    end
  end

  // read path
  logic [DATA_W-1:0] rdata_d;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  always_comb begin
    unique case (sel.kind)
      RK_PEND:  rdata_d = DATA_W'(pend_q);
      RK_PRIO:  rdata_d = DATA_W'(rd_prio);
      RK_EN:    rdata_d = DATA_W'(en_q[hsel]);
      RK_CLAIM: rdata_d = DATA_W'(claim_id);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= rd;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_rdata_q <= '0;
    end else if (rd) begin
      rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/swi_claim_ctrl_chk.sv
module swi_claim_ctrl_chk #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_HARTS-1:0] irq,
  input logic [NUM_HARTS:0]   pend_q
);

  localparam int unsigned NSRC = NUM_HARTS + 1;
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(32'h1000);

  logic rd_req, pend_rd, pend_wr, claim_rd;
  assign rd_req   = req_valid && !req_write;
  assign pend_rd  = rd_req && (req_addr == PEND_A);
  assign pend_wr  = req_valid && req_write && (req_addr == PEND_A);
  assign claim_rd = rd_req && req_addr[21] && (req_addr[11:0] == 12'h004);

  p_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd |=> (rsp_rdata[0] == 1'b0));

  p_w1s_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_claim_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> (rsp_rdata < 32'(NSRC)));

  p_claim_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> ($countones(pend_q) <= $countones($past(pend_q))));

  p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (pend_q != '0));

  p_rsp_after_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  p_no_rsp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

endmodule

bind swi_claim_ctrl swi_claim_ctrl_chk #(
  .NUM_HARTS (NUM_HARTS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .pend_q    (pend_q)
);

// File: tb/swi_claim_ctrl_test.sv
`timescale 1ns/1ps
module swi_claim_ctrl_test;

  localparam int unsigned NH = 4;
  localparam int unsigned AW = 22;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NH-1:0] irq;

  swi_claim_ctrl #(.NUM_HARTS(NH), .PRIO_W(3), .ADDR_W(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [AW-1:0] a_pend();
    return AW'(32'h1000);
  endfunction
  function automatic logic [AW-1:0] a_prio(int s);
    return AW'(4 * s);
  endfunction
  function automatic logic [AW-1:0] a_en(int h);
    return AW'(32'h2000 + 32'h80 * h);
  endfunction
  function automatic logic [AW-1:0] a_claim(int h);
    return AW'(32'h20_0004 + 32'h1000 * h);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13: unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: act=%h exp=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic [NH-1:0] e, input string t);
    n_vec++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq act=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    finish_run();
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk_irq('0, "R12 irq after reset");
    n_vec++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12: rsp_valid act=%b exp=0", rsp_valid);
    end
    bus_rd(a_pend(),   0, "R12 pending reset");
    bus_rd(a_prio(1),  0, "R12 priority reset");
    bus_rd(a_en(0),    0, "R12 enable reset");
    bus_rd(a_claim(0), 0, "R12 claim empty");

    // setup: R2 mapping, R4 enables, R5 priorities
    for (int s = 1; s <= NH; s++) bus_wr(a_prio(s), 1);
    for (int h = 0; h < NH; h++) bus_wr(a_en(h), 32'(2) << h);
    bus_rd(a_en(1),   32'h4, "R4 enable hart1");
    bus_rd(a_prio(2), 32'h1, "R2 priority word source 2");
    bus_wr(a_prio(3), 32'hFFFF_FFFF);
    bus_rd(a_prio(3), 32'h7, "R5 priority width");
    bus_wr(a_prio(3), 1);
    bus_wr(a_en(3), 32'hFFFF_FFFF);
    bus_rd(a_en(3), 32'h1E, "R4 enable stored bits, R1 bit0");
    bus_wr(a_en(3), 32'h10);

    // R1 bit 0 dropped
    bus_wr(a_pend(), 32'h1);
    chk_irq('0, "R1 bit0 raises nothing");
    bus_rd(a_pend(), 0, "R1 pending bit0");

    // R3 / R2 / R9
    bus_wr(a_pend(), 32'h8);
    chk_irq(4'b0100, "R9 R2 irq hart2");
    bus_rd(a_pend(), 32'h8, "R3 pending set");
    bus_wr(a_pend(), 32'h0);
    bus_rd(a_pend(), 32'h8, "R3 zeros clear nothing");

    // R6 / R7 claim
    bus_rd(a_claim(2), 3, "R6 claim hart2");
    chk_irq('0, "R9 irq drops after claim");
    bus_rd(a_pend(), 0, "R7 claim clears pending");
    bus_rd(a_claim(2), 0, "R7 claim nothing");

    // R8 in-service
    bus_wr(a_pend(), 32'h8);
    chk_irq('0, "R8 re-raise while in service");
    bus_rd(a_claim(2), 0, "R8 no reclaim in service");
    bus_rd(a_pend(), 32'h8, "R8 pending kept");
    bus_wr(a_claim(2), 2);
    chk_irq('0, "R8 wrong id ignored");
    bus_wr(a_claim(1), 3);
    chk_irq('0, "R8 other hart ignored");
    bus_wr(a_claim(2), 3);
    chk_irq(4'b0100, "R8 completion releases");
    bus_rd(a_claim(2), 3, "R8 reclaim after complete");
    bus_wr(a_claim(2), 3);
    chk_irq('0, "R9 idle");

    // R6 arbitration
    bus_wr(a_en(0), 32'h1E);
    bus_wr(a_prio(2), 5);
    bus_wr(a_prio(3), 5);
    bus_wr(a_pend(), 32'h1E);
    chk_irq(4'b1111, "R9 all harts");
    bus_rd(a_claim(0), 2, "R6 tie lowest id");
    bus_rd(a_claim(0), 3, "R6 next high");
    bus_rd(a_claim(0), 1, "R6 tie low prio");
    bus_rd(a_claim(0), 4, "R6 last");
    bus_rd(a_claim(0), 0, "R7 drained");
    chk_irq('0, "R9 all in service");
    for (int s = 1; s <= NH; s++) bus_wr(a_claim(0), s);
    bus_rd(a_pend(), 0, "R7 all cleared");
    bus_wr(a_prio(2), 1);
    bus_wr(a_prio(3), 1);
    bus_wr(a_en(0), 32'h2);

    // R10 priority 0
    bus_wr(a_prio(1), 0);
    bus_wr(a_pend(), 32'h2);
    chk_irq('0, "R10 prio0 no irq");
    bus_rd(a_claim(0), 0, "R10 prio0 no claim");
    bus_rd(a_pend(), 32'h2, "R10 pending held");
    bus_wr(a_prio(1), 1);
    chk_irq(4'b0001, "R10 prio restored");
    bus_rd(a_claim(0), 1, "R10 claim after restore");
    bus_wr(a_claim(0), 1);

    // hart3 path
    bus_wr(a_pend(), 32'h10);
    chk_irq(4'b1000, "R2 irq hart3");
    bus_rd(a_claim(3), 4, "R2 claim hart3");
    bus_wr(a_claim(3), 4);
    chk_irq('0, "R9 hart3 idle");

    // R11 unmapped
    bus_wr(a_prio(0), 32'h7);
    bus_rd(a_prio(0), 0, "R11 source0 priority");
    bus_rd(a_prio(NH + 1), 0, "R2 priority beyond sources");
    bus_rd(AW'(32'h1004), 0, "R11 hole");
    bus_rd(AW'(32'h1001), 0, "R11 misaligned read");
    bus_wr(AW'(32'h1002), 32'h1E);
    bus_rd(a_pend(), 0, "R11 misaligned write");
    bus_wr(a_en(NH), 32'hFF);
    bus_rd(a_en(NH), 0, "R11 enable beyond harts");
    bus_rd(a_en(0), 32'h2, "R11 enable hart0 untouched");
    bus_wr(a_pend(), 32'h2);
    bus_rd(a_claim(NH), 0, "R11 claim beyond harts");
    bus_rd(a_pend(), 32'h2, "R11 no claim side effect");
    bus_rd(a_claim(0), 1, "R6 cleanup claim");
    bus_wr(a_claim(0), 1);

    repeat (3) @(negedge clk);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R13: responses missing act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end

endmodule